// File: doc/BRIEF.md
# Two-Wire Serial Bus Master

This block is the only master on a two-wire bus made of one clock line and one data line. Both lines are open-drain. The block drives each line low through an enable output and reads the resolved data line back. On command it opens a transfer with a start condition, moves bytes most significant bit first, and closes the transfer with a stop condition. A byte normally takes nine clock pulses: eight data bits, then one handshake bit. The receiver of the byte supplies that handshake bit. When the master sends, it samples the handshake from the slave. When the master receives, it drives the handshake itself. The first byte after a start is normally the slave address. Software sends that byte like any other.

A configuration bit selects a shortened byte format. In that format a byte has exactly eight clock pulses, and no handshake bit is driven or sampled. Two configuration values set the clock. They give the number of system-clock cycles in the low half and in the high half of every bus clock period. A second configuration bit sets when the per-byte interrupt pulse fires: at the end of the eighth data bit, or after the handshake bit.

The control side has these inputs: start, stop, send-byte and receive-byte commands, a transmit byte, and a flag that chooses whether to acknowledge a received byte. The block reports a ready flag, a busy-on-bus flag, a missing-acknowledge flag, the last byte shifted, and an interrupt pulse. Repeated starts are supported. Arbitration, clock stretching and slave operation are not.

Top module: `twi_master`

## Requirements
- R1: After reset both line enables are 0 (lines released), `ready` is 1, `active` is 0, `irq` is 0 and `nack` is 0.
- R2: `cmd_start` while idle makes the data line fall while the clock line is high, then holds the clock low with `ready`=1 and `active`=1.
- R3: `tx_wr` while the bus is held puts `tx_byte` on the data line most significant bit first, one bit per clock pulse. The data line changes only while the clock line is low.
- R4: For a transmitted byte in normal mode, the data line is sampled on the ninth clock pulse. `nack` becomes 1 if the line is high and 0 if it is low.
- R5: `rx_go` while the bus is held shifts in eight bits, first bit into bit 7, and presents them on `rx_byte`. On the ninth pulse the master pulls the data line low when `rx_ack`=1 and releases it when `rx_ack`=0.
- R6: With `cfg_pseudo8`=1 a byte has exactly eight clock pulses with no handshake pulse, and a transmitted byte leaves `nack` at 0.
- R7: Every bit clock is low for max(`cfg_lo_half`,2) system cycles and high for max(`cfg_hi_half`,2) system cycles.
- R8: Each byte raises `irq` for exactly one cycle. With `cfg_irq_late`=0, or in the eight-pulse format, the pulse comes after the eighth clock pulse has risen and before any further clock rise. With `cfg_irq_late`=1 in normal mode it comes after the ninth pulse.
- R9: `cmd_stop` while the bus is held makes the data line rise while the clock line is high. Both lines then end up released, with `active`=0 and `ready`=1.
- R10: Commands arriving while `ready`=0 are ignored. `tx_wr`, `rx_go` and `cmd_stop` are ignored while idle. `ready` is 0 while a byte is in progress.
- R11: `cmd_start` while the bus is held produces a repeated start: a new start condition with no stop condition in between, and `active` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lo_half | input | DIV_W | Clock low half-period in system cycles (minimum 2 applied) |
| cfg_hi_half | input | DIV_W | Clock high half-period in system cycles (minimum 2 applied) |
| cfg_pseudo8 | input | 1 | 1 = eight-pulse bytes with no handshake bit |
| cfg_irq_late | input | 1 | 1 = interrupt after the handshake bit instead of after bit eight |
| cmd_start | input | 1 | Start or repeated-start request (one-cycle pulse) |
| cmd_stop | input | 1 | Stop request (one-cycle pulse) |
| tx_wr | input | 1 | Send `tx_byte` (one-cycle pulse) |
| tx_byte | input | 8 | Byte to transmit |
| rx_go | input | 1 | Receive one byte (one-cycle pulse) |
| rx_ack | input | 1 | 1 = acknowledge the received byte |
| rx_byte | output | 8 | Last byte shifted in from the data line |
| ready | output | 1 | Block can accept a command |
| active | output | 1 | Bus is owned (between start and end of stop) |
| nack | output | 1 | Last transmitted byte was not acknowledged |
| irq | output | 1 | One-cycle per-byte interrupt pulse |
| scl_oe | output | 1 | 1 = pull the clock line low |
| sda_oe | output | 1 | 1 = pull the data line low |
| sda_in | input | 1 | Resolved level of the data line |

## Verification
The hardest situation to reach from the ports is the handshake slot. The data line must be driven by the right party, and sampled, on exactly the ninth pulse. The interrupt must land on the right side of that pulse. The bench therefore wires in a bus-level slave model. The model counts clock falls from each command and pulls the line low for data or handshake bits at the matching index. Every byte value is swept in both directions with the handshake answer varied, so the sampled and driven bit lands in both polarities. Eight-pulse bytes, both interrupt placements, repeated starts, and commands issued in the middle of a byte are exercised at several half-period settings, including settings below the minimum.

// File: rtl/twi_pkg.sv
package twi_pkg;
    localparam int BYTE_W = 8;
    localparam int BCNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_HOLD,
        ST_RS_LO,
        ST_RS_HI,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_STOP_LO,
        ST_STOP_HI,
        ST_STOP_FREE
    } twi_state_e;
endpackage

// File: rtl/twi_phase_timer.sv
module twi_phase_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] len,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign done = (cnt_q == '0);

    always_comb begin
        if (restart) begin
            cnt_d = len - CNT_W'(1);
        end else if (done) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/twi_shift_reg.sv
module twi_shift_reg
    import twi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_val,
    input  logic              shift,
    input  logic              sin,
    output logic [BYTE_W-1:0] data,
    output logic [BCNT_W-1:0] count
);
    logic [BYTE_W-1:0] data_d, data_q;
    logic [BCNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        data_d = data_q;
        cnt_d  = cnt_q;
        if (load) begin
            data_d = load_val;
            cnt_d  = '0;
        end else if (shift) begin
            data_d = {data_q[BYTE_W-2:0], sin};
            cnt_d  = cnt_q + BCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            cnt_q  <= '0;
        end else begin
            data_q <= data_d;
            cnt_q  <= cnt_d;
        end
    end

    assign data  = data_q;
    assign count = cnt_q;

    // R6: the bit counter never runs past one byte
    a_r6_bitcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= BCNT_W'(BYTE_W));
endmodule

// File: rtl/twi_master.sv
module twi_master
    import twi_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  cfg_lo_half,
    input  logic [DIV_W-1:0]  cfg_hi_half,
    input  logic              cfg_pseudo8,
    input  logic              cfg_irq_late,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              rx_go,
    input  logic              rx_ack,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ready,
    output logic              active,
    output logic              nack,
    output logic              irq,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

    typedef struct packed {
        twi_state_e        state;
        logic              rxmode;
        logic              ackdrv;
        logic              nack;
        logic              irq;
        logic              sda_oe;
        logic [BYTE_W-1:0] rxdata;
    } regs_t;

    regs_t r_q, r_d;

    logic              tmr_done;
    logic              tmr_restart;
    logic [DIV_W-1:0]  tmr_len;
    logic [DIV_W-1:0]  lo_eff, hi_eff;
    logic              sh_load, sh_shift;
    logic [BYTE_W-1:0] sh_data;
    logic [BCNT_W-1:0] sh_cnt;
    logic              low_next;

    assign lo_eff = (cfg_lo_half < MIN_HALF) ? MIN_HALF : cfg_lo_half;
    assign hi_eff = (cfg_hi_half < MIN_HALF) ? MIN_HALF : cfg_hi_half;

    function automatic logic is_low_phase(input twi_state_e s);
        return (s == ST_HOLD) || (s == ST_RS_LO) || (s == ST_BIT_LO) ||
               (s == ST_ACK_LO) || (s == ST_STOP_LO);
    endfunction

    always_comb begin
        r_d      = r_q;
        r_d.irq  = 1'b0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                if (cmd_start) r_d.state = ST_START;
            end
            ST_HOLD: begin
                if (cmd_start) begin
                    r_d.state = ST_RS_LO;
                end else if (cmd_stop) begin
                    r_d.state = ST_STOP_LO;
                end else if (tx_wr) begin
                    sh_load    = 1'b1;
                    r_d.rxmode = 1'b0;
                    r_d.nack   = 1'b0;
                    r_d.state  = ST_BIT_LO;
                end else if (rx_go) begin
                    sh_load    = 1'b1;
                    r_d.rxmode = 1'b1;
                    r_d.ackdrv = rx_ack;
                    r_d.state  = ST_BIT_LO;
                end
            end
            ST_START:   if (tmr_done) r_d.state = ST_HOLD;
            ST_RS_LO:   if (tmr_done) r_d.state = ST_RS_HI;
            ST_RS_HI:   if (tmr_done) r_d.state = ST_START;
            ST_BIT_LO:  if (tmr_done) r_d.state = ST_BIT_HI;
            ST_BIT_HI: begin
                if (tmr_done) begin
                    sh_shift = 1'b1;
                    if (sh_cnt == BCNT_W'(BYTE_W - 1)) begin
                        r_d.rxdata = {sh_data[BYTE_W-2:0], sda_in};
                        if (cfg_pseudo8) begin
                            r_d.state = ST_HOLD;
                            r_d.irq   = 1'b1;
                        end else begin
                            r_d.state = ST_ACK_LO;
                            r_d.irq   = !cfg_irq_late;
                        end
                    end else begin
                        r_d.state = ST_BIT_LO;
                    end
                end
            end
            ST_ACK_LO:  if (tmr_done) r_d.state = ST_ACK_HI;
            ST_ACK_HI: begin
                if (tmr_done) begin
                    if (!r_q.rxmode) r_d.nack = sda_in;
                    r_d.irq   = cfg_irq_late;
                    r_d.state = ST_HOLD;
                end
            end
            ST_STOP_LO:   if (tmr_done) r_d.state = ST_STOP_HI;
            ST_STOP_HI:   if (tmr_done) r_d.state = ST_STOP_FREE;
            ST_STOP_FREE: if (tmr_done) r_d.state = ST_IDLE;
            default:      r_d.state = ST_IDLE;
        endcase

        // data line follows the current phase one cycle late, so it only
        // moves after the clock line has already gone low
        case (r_q.state)
            ST_START, ST_STOP_LO, ST_STOP_HI: r_d.sda_oe = 1'b1;
            ST_HOLD:                          r_d.sda_oe = r_q.sda_oe;
            ST_BIT_LO, ST_BIT_HI:
                r_d.sda_oe = r_q.rxmode ? 1'b0 : !sh_data[BYTE_W-1];
            ST_ACK_LO, ST_ACK_HI:
                r_d.sda_oe = r_q.rxmode ? r_q.ackdrv : 1'b0;
            default:                          r_d.sda_oe = 1'b0;
        endcase
    end

    assign low_next    = is_low_phase(r_d.state);
    assign tmr_restart = (r_d.state != r_q.state);
    assign tmr_len     = low_next ? lo_eff : hi_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    twi_phase_timer #(.CNT_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .len     (tmr_len),
        .done    (tmr_done)
    );

    twi_shift_reg u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val (tx_byte),
        .shift    (sh_shift),
        .sin      (sda_in),
        .data     (sh_data),
        .count    (sh_cnt)
    );

    assign scl_oe  = is_low_phase(r_q.state);
    assign sda_oe  = r_q.sda_oe;
    assign ready   = (r_q.state == ST_IDLE) || (r_q.state == ST_HOLD);
    assign active  = (r_q.state != ST_IDLE);
    assign nack    = r_q.nack;
    assign irq     = r_q.irq;
    assign rx_byte = r_q.rxdata;

    // R3: data enable holds still while the clock stays released in a bit
    a_r3_sda_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) &&
         (r_q.state == ST_BIT_HI || r_q.state == ST_ACK_HI)) |-> $stable(r_q.sda_oe));

    // R8: interrupt is a single-cycle pulse
    a_r8_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R4: missing acknowledge is only recorded out of the handshake phase
    a_r4_nack_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nack) |-> $past(r_q.state == ST_ACK_HI));

    // R9: releasing data with the clock high happens only when closing the bus
    a_r9_rise_only_stop: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe) |-> (r_q.state == ST_STOP_FREE));
endmodule

// File: tb/twi_master_tb.sv
module twi_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIV_W-1:0] cfg_lo_half = 8'd2;
    logic [DIV_W-1:0] cfg_hi_half = 8'd2;
    logic cfg_pseudo8 = 1'b0;
    logic cfg_irq_late = 1'b0;
    logic cmd_start = 1'b0;
    logic cmd_stop = 1'b0;
    logic tx_wr = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic rx_go = 1'b0;
    logic rx_ack = 1'b0;
    logic [7:0] rx_byte;
    logic ready, active, nack, irq, scl_oe, sda_oe;
    logic sda_in;

    // bus and slave model
    logic slave_low;
    logic slv_send = 1'b0;
    logic slv_ack = 1'b0;
    logic [7:0] slv_pat = 8'h00;
    int byte_base = 0;
    logic scl_line, sda_line;

    int rises = 0, falls = 0, starts = 0, stops = 0, irq_cnt = 0, irq_pos = 0;
    int hi_run = 0, lo_run = 0, hi_last = 0, lo_last = 0;
    logic [15:0] cap = '0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        int idx;
        idx = falls - byte_base;
        if (slv_send) slave_low = (idx >= 0 && idx < 8) ? !slv_pat[7-idx] : 1'b0;
        else          slave_low = slv_ack && (idx == 8);
    end

    assign scl_line = !scl_oe;
    assign sda_line = !(sda_oe || slave_low);
    assign sda_in   = sda_line;

    twi_master #(.DIV_W(DIV_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_lo_half(cfg_lo_half), .cfg_hi_half(cfg_hi_half),
        .cfg_pseudo8(cfg_pseudo8), .cfg_irq_late(cfg_irq_late),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .tx_wr(tx_wr), .tx_byte(tx_byte), .rx_go(rx_go), .rx_ack(rx_ack),
        .rx_byte(rx_byte), .ready(ready), .active(active), .nack(nack),
        .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    // bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (scl_line && !prev_scl) begin
                rises   <= rises + 1;
                cap     <= {cap[14:0], sda_line};
                lo_last <= lo_run;
                lo_run  <= 0;
                hi_run  <= 1;
            end else if (!scl_line && prev_scl) begin
                falls   <= falls + 1;
                hi_last <= hi_run;
                hi_run  <= 0;
                lo_run  <= 1;
            end else if (scl_line) begin
                hi_run <= hi_run + 1;
            end else begin
                lo_run <= lo_run + 1;
            end
            if (scl_line && prev_scl && prev_sda && !sda_line) starts <= starts + 1;
            if (scl_line && prev_scl && !prev_sda && sda_line) stops  <= stops + 1;
            if (irq) begin
                irq_cnt <= irq_cnt + 1;
                irq_pos <= rises + ((scl_line && !prev_scl) ? 1 : 0);
            end
            prev_scl <= scl_line;
            prev_sda <= sda_line;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v < 2) ? 2 : v;
    endfunction

    task automatic wait_ready();
        @(negedge clk);
        while (!ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_start(input logic repeated);
        int s0, p0;
        s0 = starts; p0 = stops;
        @(negedge clk) cmd_start = 1'b1;
        @(negedge clk) cmd_start = 1'b0;
        wait_ready();
        if (repeated) begin
            chk("R11 repeated start seen", starts - s0, 1);
            chk("R11 no stop in between", stops - p0, 0);
            chk("R11 still active", active, 1);
        end else begin
            chk("R2 start condition", starts - s0, 1);
            chk("R2 active", active, 1);
            chk("R2 clock held low", scl_line, 0);
        end
    endtask

    task automatic do_stop();
        int p0;
        p0 = stops;
        @(negedge clk) cmd_stop = 1'b1;
        @(negedge clk) cmd_stop = 1'b0;
        wait_ready();
        chk("R9 stop condition", stops - p0, 1);
        chk("R9 inactive", active, 0);
        chk("R9 lines released", {30'd0, scl_line, sda_line}, 3);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic ack);
        int r0, i0, nb;
        r0 = rises; i0 = irq_cnt;
        slv_send = 1'b0; slv_ack = ack && !cfg_pseudo8; byte_base = falls;
        @(negedge clk) begin tx_byte = v; tx_wr = 1'b1; end
        @(negedge clk) tx_wr = 1'b0;
        chk("R10 busy not ready", ready, 0);
        wait_ready();
        nb = cfg_pseudo8 ? 8 : 9;
        if (cfg_pseudo8) begin
            chk("R6 eight pulses", rises - r0, 8);
            chk("R6 data msb first", cap[7:0], v);
            chk("R6 nack clear", nack, 0);
        end else begin
            chk("R3 nine pulses", rises - r0, 9);
            chk("R3 data msb first", cap[8:1], v);
            chk("R4 ack line level", cap[0], !ack);
            chk("R4 nack flag", nack, !ack);
        end
        chk("R8 one irq", irq_cnt - i0, 1);
        chk("R8 irq position", irq_pos - r0, (cfg_irq_late && !cfg_pseudo8) ? 9 : 8);
        chk("R7 high half", hi_last, eff(cfg_hi_half));
        chk("R7 low half", lo_last, eff(cfg_lo_half));
        slv_ack = 1'b0;
        if (nb == 0) chk("R3 unreachable", 0, 1);
    endtask

    task automatic recv_byte(input logic [7:0] p, input logic a);
        int r0, i0;
        r0 = rises; i0 = irq_cnt;
        slv_send = 1'b1; slv_ack = 1'b0; slv_pat = p; byte_base = falls;
        @(negedge clk) begin rx_ack = a; rx_go = 1'b1; end
        @(negedge clk) rx_go = 1'b0;
        wait_ready();
        chk("R5 received byte", rx_byte, p);
        if (cfg_pseudo8) begin
            chk("R6 eight pulses rx", rises - r0, 8);
        end else begin
            chk("R5 pulses rx", rises - r0, 9);
            chk("R5 master ack level", cap[0], !a);
        end
        chk("R8 one irq rx", irq_cnt - i0, 1);
        slv_send = 1'b0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 15000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int los[3] = '{1, 3, 2};
        int his[3] = '{1, 2, 5};
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 scl released", scl_oe, 0);
        chk("R1 sda released", sda_oe, 0);
        chk("R1 ready", ready, 1);
        chk("R1 inactive", active, 0);
        chk("R1 irq low", irq, 0);
        chk("R1 nack low", nack, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R10 commands ignored while idle
        @(negedge clk) begin tx_wr = 1'b1; rx_go = 1'b1; cmd_stop = 1'b1; end
        @(negedge clk) begin tx_wr = 1'b0; rx_go = 1'b0; cmd_stop = 1'b0; end
        repeat (20) @(negedge clk);
        chk("R10 idle no clocks", rises, 0);
        chk("R10 idle inactive", active, 0);
        chk("R10 idle data released", sda_line, 1);

        for (int c = 0; c < 3; c++) begin
            for (int l = 0; l < 2; l++) begin
                cfg_lo_half = DIV_W'(los[c]);
                cfg_hi_half = DIV_W'(his[c]);
                cfg_irq_late = l[0];
                do_start(1'b0);
                for (int k = 0; k < 4; k++) send_byte(8'(37 * k + c * 11 + l * 5 + 8'h5A), k[0]);
                recv_byte(8'(8'hC3 ^ (c * 29 + l)), 1'b1);
                recv_byte(8'(8'h3C + c * 7), 1'b0);
                cfg_pseudo8 = 1'b1;
                send_byte(8'(8'h96 + c + l), 1'b1);
                recv_byte(8'(8'h69 - c), 1'b1);
                cfg_pseudo8 = 1'b0;
                do_start(1'b1);
                do_stop();
            end
        end

        // R10 commands during a byte are ignored
        cfg_lo_half = 8'd2; cfg_hi_half = 8'd3; cfg_irq_late = 1'b0;
        do_start(1'b0);
        begin
            int r0, s0, p0;
            r0 = rises; s0 = starts; p0 = stops;
            slv_send = 1'b0; slv_ack = 1'b1; byte_base = falls;
            @(negedge clk) begin tx_byte = 8'hA5; tx_wr = 1'b1; end
            @(negedge clk) tx_wr = 1'b0;
            repeat (3) @(negedge clk);
            @(negedge clk) begin tx_wr = 1'b1; cmd_stop = 1'b1; cmd_start = 1'b1; rx_go = 1'b1; end
            @(negedge clk) begin tx_wr = 1'b0; cmd_stop = 1'b0; cmd_start = 1'b0; rx_go = 1'b0; end
            wait_ready();
            repeat (30) @(negedge clk);
            chk("R10 busy one byte only", rises - r0, 9);
            chk("R10 busy no start", starts - s0, 0);
            chk("R10 busy no stop", stops - p0, 0);
            chk("R10 busy still active", active, 1);
            slv_ack = 1'b0;
        end

        // exhaustive byte sweep in both directions
        for (int v = 0; v < 256; v++) send_byte(8'(v), v[0] ^ v[7]);
        for (int v = 0; v < 256; v++) recv_byte(8'(v), v[1]);
        do_stop();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule